// File: doc/BRIEF.md
# Descriptor Submit Queue Register Block

This block keeps up to eight 64-bit context descriptors that software stages before handing them to an execution engine. A plain 32-bit register bus writes and reads the block. A load strobe and a parallel copy of every slot go out to the engine.

Software can fill the queue in two ways:
- **Submit port.** A single register is written repeatedly. Each descriptor takes two writes, upper word first and then lower word. A cyclic slot pointer walks from slot 0 up to slot 7 and then wraps.
- **Direct window.** Each slot is reached by address. Slot n's lower word sits at word offset 2n from the window base (byte offset 0x510). Its upper word sits at word offset 2n+1.

Writing 1 to bit 0 of the command register (byte offset 0x550) loads the queue into the engine. The block then raises the strobe for one cycle and presents a registered snapshot of all slots. It also presents a mask that marks which slots hold a non-zero descriptor, since a zero descriptor means the slot is unused. A load leaves the slots untouched, so stale entries stay until software rewrites them.

Three small state machines run the block:
- **Port sequencer.** Its states are `PH_HIGH` and `PH_LOW`.
  - `PH_HIGH` goes to `PH_LOW` on a port write, which captures the upper word.
  - `PH_LOW` goes to `PH_HIGH` on a port write, which commits the slot and advances the pointer.
  - Any state goes to `PH_HIGH` on a load command, which also resets the pointer to 0.
- **Load control.** Its states are `LD_IDLE` and `LD_PULSE`.
  - Any state goes to `LD_PULSE` on a load command.
  - `LD_PULSE` goes back to `LD_IDLE` on the next cycle unless another load command arrives.
- **Address decoder.** It is combinational and classifies each access as `SEL_WIN`, `SEL_PORT`, `SEL_CTL` or `SEL_NONE`.

Top module: `esq_submit_queue`

## Requirements
- R1: After reset, every slot is zero, the strobe is low, the snapshot and used mask are zero, and the port pointer is at slot 0 expecting an upper word.
- R2: A write to byte offset 0x510 + 8n sets the lower 32 bits of slot n, and a write to 0x514 + 8n sets its upper 32 bits. The other half of the slot is unchanged. Reads at those offsets return the stored word one cycle after the request, with `bus_rvalid` high.
- R3: A write to the submit port (byte offset 0x230) in the upper-word phase changes no slot. The next port write commits {held upper word, written lower word} to the slot under the pointer.
- R4: The pointer advances by one after each committed descriptor, in the order 0,1,…,7, and wraps from 7 to 0.
- R5: A write to 0x550 with bit 0 = 1 raises `load_strobe` for exactly the next cycle. `load_desc[64n+63:64n]` then equals slot n as it was before that write. With bit 0 = 0, no strobe is raised.
- R6: A load leaves every slot's contents unchanged.
- R7: A load resets the pointer to slot 0 and discards a pending upper word.
- R8: Reads of the command register return 0.
- R9: Writes to unmapped or misaligned offsets change no slot, and reads of them return 0.
- R10: `load_desc` and `load_used` hold their values between loads, even while slots are being rewritten.
- R11: `load_used[n]` is 1 exactly when the snapshot of slot n is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address relative to the engine base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| load_strobe | output | 1 | One-cycle load pulse to the engine |
| load_desc | output | 512 | Snapshot of all slots, slot n at bits 64n+63:64n |
| load_used | output | 8 | Bit n set when snapshot slot n is non-zero |

## Verification
Two things can happen in the same cycle: the load strobe with its fresh snapshot, and the next bus write, which may rewrite a slot that has just been captured. The bench issues a slot write back-to-back after a load command. It also mixes random window writes and port writes right behind random load commands. It then checks that the snapshot seen during the strobe matches the slots as they were before the load, and that the snapshot stays unchanged after the strobe drops. A read of the rewritten slot must return the new value, and the pointer must restart at slot 0 even when an upper word was pending at the moment of the load.

// File: rtl/esq_pkg.sv
package esq_pkg;

    // Target selected by the address decoder
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_WIN,
        SEL_PORT,
        SEL_CTL
    } esq_sel_e;

    // Submit-port word phase
    typedef enum logic {
        PH_HIGH,
        PH_LOW
    } esq_phase_e;

    // Load strobe control
    typedef enum logic {
        LD_IDLE,
        LD_PULSE
    } esq_load_e;

endpackage

// File: rtl/esq_bus_decode.sv
module esq_bus_decode
    import esq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_SLOTS = 8,
    parameter int                IDX_W     = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h510,
    parameter logic [ADDR_W-1:0] CTL_OFFS  = 12'h550,
    parameter logic [ADDR_W-1:0] PORT_OFFS = 12'h230
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output esq_sel_e          sel,
    output logic [IDX_W-1:0]  win_slot,
    output logic              win_hi
);

    localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(NUM_SLOTS * 8);

    logic [ADDR_W-1:0] offs;

    assign offs = bus_addr - WIN_BASE;

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            // unsigned wrap makes addresses below the base fail this compare
            if (offs < WIN_BYTES) begin
                sel = SEL_WIN;
            end else if (bus_addr == CTL_OFFS) begin
                sel = SEL_CTL;
            end else if (bus_addr == PORT_OFFS) begin
                sel = SEL_PORT;
            end
        end
    end

    assign win_slot = offs[IDX_W+2:3];
    assign win_hi   = offs[2];

endmodule

// File: rtl/esq_port_seq.sv
module esq_port_seq
    import esq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_wr,
    input  logic             load_cmd,
    input  logic [31:0]      wdata,
    output logic             commit,
    output logic [IDX_W-1:0] commit_idx,
    output logic [63:0]      commit_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

    esq_phase_e       phase_q, phase_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [31:0]      hold_q, hold_d;

    // next-state logic
    always_comb begin
        phase_d = phase_q;
        ptr_d   = ptr_q;
        hold_d  = hold_q;
        if (load_cmd) begin
            phase_d = PH_HIGH;
            ptr_d   = '0;
        end else if (port_wr) begin
            unique case (phase_q)
                PH_HIGH: begin
                    hold_d  = wdata;
                    phase_d = PH_LOW;
                end
                PH_LOW: begin
                    phase_d = PH_HIGH;
                    ptr_d   = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
                end
                default: phase_d = PH_HIGH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HIGH;
            ptr_q   <= '0;
            hold_q  <= '0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
            hold_q  <= hold_d;
        end
    end

    // outputs
    always_comb begin
        commit      = port_wr && (phase_q == PH_LOW) && !load_cmd;
        commit_idx  = ptr_q;
        commit_data = {hold_q, wdata};
    end

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !load_cmd && phase_q == PH_LOW) |=>
            (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1)));

    p_ptr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd |=> (ptr_q == '0 && phase_q == PH_HIGH));

    p_high_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !load_cmd && phase_q == PH_HIGH) |=>
            (phase_q == PH_LOW && hold_q == $past(wdata)));

endmodule

// File: rtl/esq_slot_store.sv
module esq_slot_store #(
    parameter int NUM_SLOTS = 8,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   win_wr,
    input  logic [IDX_W-1:0]       win_slot,
    input  logic                   win_hi,
    input  logic [31:0]            wdata,
    input  logic                   commit,
    input  logic [IDX_W-1:0]       commit_idx,
    input  logic [63:0]            commit_data,
    output logic [NUM_SLOTS*64-1:0] slots_flat,
    output logic [31:0]            rd_word
);

    logic [63:0] slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (commit && commit_idx == IDX_W'(g)) begin
                slot_q[g] <= commit_data;
            end else if (win_wr && win_slot == IDX_W'(g)) begin
                if (win_hi) begin
                    slot_q[g][63:32] <= wdata;
                end else begin
                    slot_q[g][31:0] <= wdata;
                end
            end
        end
        assign slots_flat[g*64 +: 64] = slot_q[g];
    end

    assign rd_word = win_hi ? slot_q[win_slot][63:32] : slot_q[win_slot][31:0];

    p_commit_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (slot_q[$past(commit_idx)] == $past(commit_data)));

    p_window_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !commit) |=> (rd_word == $past(wdata) || win_slot != $past(win_slot)
                                 || win_hi != $past(win_hi)));

endmodule

// File: rtl/esq_load_ctrl.sv
module esq_load_ctrl
    import esq_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_cmd,
    input  logic [NUM_SLOTS*64-1:0] slots_flat,
    output logic                    load_strobe,
    output logic [NUM_SLOTS*64-1:0] load_desc,
    output logic [NUM_SLOTS-1:0]    load_used
);

    esq_load_e              st_q, st_d;
    logic [NUM_SLOTS*64-1:0] desc_q;
    logic [NUM_SLOTS-1:0]    used_q, used_d;

    always_comb begin
        unique case (st_q)
            LD_IDLE:  st_d = load_cmd ? LD_PULSE : LD_IDLE;
            LD_PULSE: st_d = load_cmd ? LD_PULSE : LD_IDLE;
            default:  st_d = LD_IDLE;
        endcase
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_used
        assign used_d[g] = |slots_flat[g*64 +: 64];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= LD_IDLE;
            desc_q <= '0;
            used_q <= '0;
        end else begin
            st_q <= st_d;
            if (load_cmd) begin
                desc_q <= slots_flat;
                used_q <= used_d;
            end
        end
    end

    always_comb begin
        load_strobe = (st_q == LD_PULSE);
        load_desc   = desc_q;
        load_used   = used_q;
    end

    p_strobe_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> $past(load_cmd));

    p_snapshot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |-> ($stable(load_desc) && $stable(load_used)));

    p_snapshot_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd |=> (load_desc == $past(slots_flat)));

endmodule

// File: rtl/esq_submit_queue.sv
module esq_submit_queue
    import esq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_SLOTS = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 12'h510,
    parameter logic [ADDR_W-1:0] CTL_OFFS  = 12'h550,
    parameter logic [ADDR_W-1:0] PORT_OFFS = 12'h230
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_rvalid,
    output logic                    load_strobe,
    output logic [NUM_SLOTS*64-1:0] load_desc,
    output logic [NUM_SLOTS-1:0]    load_used
);

    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    esq_sel_e              sel;
    logic [IDX_W-1:0]      win_slot;
    logic                  win_hi;
    logic                  win_wr, port_wr, load_cmd, rd_req;
    logic                  commit;
    logic [IDX_W-1:0]      commit_idx;
    logic [63:0]           commit_data;
    logic [NUM_SLOTS*64-1:0] slots_flat;
    logic [31:0]           rd_word;
    logic [31:0]           rdata_q;
    logic                  rvalid_q;

    esq_bus_decode #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W),
        .WIN_BASE(WIN_BASE), .CTL_OFFS(CTL_OFFS), .PORT_OFFS(PORT_OFFS)
    ) u_decode (
        .bus_addr (bus_addr),
        .sel      (sel),
        .win_slot (win_slot),
        .win_hi   (win_hi)
    );

    assign win_wr   = bus_req && bus_we && (sel == SEL_WIN);
    assign port_wr  = bus_req && bus_we && (sel == SEL_PORT);
    assign load_cmd = bus_req && bus_we && (sel == SEL_CTL) && bus_wdata[0];
    assign rd_req   = bus_req && !bus_we;

    esq_port_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_wr     (port_wr),
        .load_cmd    (load_cmd),
        .wdata       (bus_wdata),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data)
    );

    esq_slot_store #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_wr      (win_wr),
        .win_slot    (win_slot),
        .win_hi      (win_hi),
        .wdata       (bus_wdata),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_data (commit_data),
        .slots_flat  (slots_flat),
        .rd_word     (rd_word)
    );

    esq_load_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_load (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_cmd    (load_cmd),
        .slots_flat  (slots_flat),
        .load_strobe (load_strobe),
        .load_desc   (load_desc),
        .load_used   (load_used)
    );

    // registered read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_req;
            rdata_q  <= (rd_req && sel == SEL_WIN) ? rd_word : '0;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    p_ctl_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && sel == SEL_CTL) |-> (bus_rvalid && bus_rdata == '0));

    p_unmapped_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && sel == SEL_NONE) |-> (bus_rvalid && bus_rdata == '0));

    p_unmapped_write_inert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && sel == SEL_NONE) |=> $stable(slots_flat));

    p_load_keeps_slots_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd |=> $stable(slots_flat));

endmodule

// File: tb/esq_submit_queue_tb_top.sv
`timescale 1ns/1ps
module esq_submit_queue_tb_top;

    localparam logic [11:0] WIN  = 12'h510;
    localparam logic [11:0] CTL  = 12'h550;
    localparam logic [11:0] PORT = 12'h230;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic         load_strobe;
    logic [511:0] load_desc;
    logic [7:0]   load_used;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_slot [8];
    logic [63:0] m_snap [8];
    int          m_ptr;
    bit          m_lo;
    logic [31:0] m_hold;

    always #4 clk = ~clk;

    esq_submit_queue dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .load_strobe(load_strobe),
        .load_desc(load_desc), .load_used(load_used)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] win_addr(input int slot, input bit hi);
        return WIN + 12'(slot * 8) + (hi ? 12'd4 : 12'd0);
    endfunction

    // one bus cycle; returns 2 ns after the sampling edge
    task automatic bus_op(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #2;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic check_load_side(input bit exp_strobe, input string tag);
        chk(tag, 64'(load_strobe), 64'(exp_strobe));
        for (int i = 0; i < 8; i++) begin
            chk(tag, load_desc[i*64 +: 64], m_snap[i]);
            chk({tag, " used R11"}, 64'(load_used[i]), 64'(m_snap[i] != 64'd0));
        end
    endtask

    task automatic wr_window(input int slot, input bit hi, input logic [31:0] d);
        bus_op(1'b1, win_addr(slot, hi), d);
        if (hi) m_slot[slot][63:32] = d; else m_slot[slot][31:0] = d;
    endtask

    task automatic wr_port(input logic [31:0] d);
        bus_op(1'b1, PORT, d);
        if (!m_lo) begin
            m_hold = d; m_lo = 1'b1;
        end else begin
            m_slot[m_ptr] = {m_hold, d};
            m_ptr = (m_ptr + 1) % 8;
            m_lo = 1'b0;
        end
    endtask

    task automatic wr_ctl(input logic [31:0] d);
        bus_op(1'b1, CTL, d);
        if (d[0]) begin
            for (int i = 0; i < 8; i++) m_snap[i] = m_slot[i];
            m_ptr = 0; m_lo = 1'b0;
            check_load_side(1'b1, "R5 load strobe/snapshot");
        end else begin
            check_load_side(1'b0, "R5 no strobe for bit0=0");
        end
    endtask

    task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string tag);
        bus_op(1'b0, a, 32'h0);
        chk(tag, 64'(bus_rvalid), 64'd1);
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_check(win_addr(i, 1'b0), m_slot[i][31:0], tag);
            rd_check(win_addr(i, 1'b1), m_slot[i][63:32], tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] bad [6];
        void'($urandom(32'h5eed_0c2a));
        for (int i = 0; i < 8; i++) begin m_slot[i] = '0; m_snap[i] = '0; end
        m_ptr = 0; m_lo = 1'b0; m_hold = '0;
        bad[0] = 12'h000; bad[1] = 12'h50C; bad[2] = 12'h511;
        bad[3] = 12'h554; bad[4] = 12'h234; bad[5] = 12'hFFC;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #10;

        // R1 reset state
        check_load_side(1'b0, "R1 reset outputs");
        rd_all("R1 reset slots zero");

        // R2 direct window halves
        wr_window(3, 1'b0, 32'hA5A5_0003);
        wr_window(3, 1'b1, 32'h1234_5678);
        rd_check(win_addr(3, 1'b0), 32'hA5A5_0003, "R2 slot3 low");
        rd_check(win_addr(3, 1'b1), 32'h1234_5678, "R2 slot3 high");
        wr_window(3, 1'b0, 32'h0000_BEEF);
        rd_check(win_addr(3, 1'b1), 32'h1234_5678, "R2 other half kept");

        // R3 high word alone commits nothing; R1 pointer starts at slot 0
        wr_port(32'hCAFE_0000);
        rd_check(win_addr(0, 1'b1), 32'h0, "R3 high word alone");
        wr_port(32'h0000_0001);
        rd_check(win_addr(0, 1'b1), 32'hCAFE_0000, "R3 commit high");
        rd_check(win_addr(0, 1'b0), 32'h0000_0001, "R3 commit low");

        // R4 fill 1..7 then wrap to 0
        for (int i = 1; i <= 8; i++) begin
            wr_port(32'hD000_0000 + 32'(i));
            wr_port(32'h0000_1000 + 32'(i));
        end
        rd_check(win_addr(7, 1'b0), 32'h0000_1007, "R4 slot7");
        rd_check(win_addr(0, 1'b1), 32'hD000_0008, "R4 wrap to slot0");

        // R5/R10 load then a back-to-back write to slot 0 during the strobe
        wr_window(5, 1'b0, 32'h0); wr_window(5, 1'b1, 32'h0);
        wr_ctl(32'h1);
        wr_window(0, 1'b0, 32'h7777_7777);
        check_load_side(1'b0, "R10 snapshot held after strobe");
        rd_check(win_addr(0, 1'b0), 32'h7777_7777, "R10 slot rewritten");
        chk("R11 unused slot5", 64'(load_used[5]), 64'd0);

        // R6 slots survive a load
        rd_all("R6 slots kept after load");

        // R5 bit0 clear gives no strobe
        wr_ctl(32'hFFFF_FFFE);

        // R7 pending high word dropped, pointer back to 0
        wr_port(32'h1111_1111);
        wr_port(32'h2222_2222);
        wr_port(32'h3333_3333);
        wr_ctl(32'h1);
        wr_port(32'h4444_4444);
        wr_port(32'h5555_5555);
        rd_check(win_addr(0, 1'b1), 32'h4444_4444, "R7 restart high");
        rd_check(win_addr(0, 1'b0), 32'h5555_5555, "R7 restart low");

        // R8 command register reads zero
        rd_check(CTL, 32'h0, "R8 ctl read");

        // R9 unmapped writes inert, reads zero
        for (int i = 0; i < 6; i++) begin
            bus_op(1'b1, bad[i], 32'hFFFF_FFFF);
            check_load_side(1'b0, "R9 unmapped write no load");
            rd_check(bad[i], 32'h0, "R9 unmapped read");
        end
        rd_all("R9 slots unchanged");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 2) begin
                wr_port($urandom());
                check_load_side(1'b0, "R10 hold during port write");
            end else if (op <= 4) begin
                wr_window($urandom_range(0, 7), 1'($urandom_range(0, 1)),
                          ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom());
                check_load_side(1'b0, "R10 hold during window write");
            end else if (op <= 6) begin
                int s; bit h;
                s = $urandom_range(0, 7); h = 1'($urandom_range(0, 1));
                rd_check(win_addr(s, h), h ? m_slot[s][63:32] : m_slot[s][31:0], "R2 random read");
            end else if (op == 7) begin
                wr_ctl({$urandom_range(0, 65535), 15'h0, 1'($urandom_range(0, 3) != 0)});
            end else if (op == 8) begin
                bus_op(1'b1, bad[$urandom_range(0, 5)], $urandom());
                check_load_side(1'b0, "R9 random unmapped write");
            end else begin
                rd_check(bad[$urandom_range(0, 5)], 32'h0, "R9 random unmapped read");
            end
        end
        rd_all("R6 final slot contents");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule